// File: doc/BRIEF.md
# Virtualization-Aware Exception Request Arbiter

This block sits beside a processor core's exception-entry logic and decides which pending request the core should take next. Requests come from three maskable physical sources (normal interrupt, fast interrupt, asynchronous abort), two virtual interrupt lines, and two unmaskable events (reset and send-event). A hypervisor control word routes each class to the virtual path and can inject virtual requests directly. The arbiter ranks every qualified source in one fixed order and registers the winner as a 3-bit cause code with a one-cycle take strobe.

Two further outputs are purely combinational. The wake output tells a core that is waiting for an interrupt whether to resume. It deliberately ignores the status-register mask bits. The status word reports, per class, either the physical or the virtual pending state, chosen by the routing bits. Its bits sit where a neighbouring status-register decoder expects them.

The registered part holds a single piece of state, the cause register, with two named conditions. IDLE means no take is presented. TAKE means a cause is presented for one cycle. Moving from IDLE to TAKE, or staying in TAKE, happens on any clock edge where some source qualifies. Moving from TAKE to IDLE, or staying in IDLE, happens when none qualifies or reset is high.

Top module: `exc_prio_top`

## Requirements
- R1: Among qualified sources the winner follows a fixed order, highest first. The cause code is the position in this order: 0 physical IRQ, 1 virtual IRQ, 2 physical FIQ, 3 virtual FIQ, 4 physical abort, 5 virtual abort, 6 reset, 7 send-event.
- R2: A virtual IRQ is pending when `req_virq` or the IRQ injection bit `hyp_ctl[3]` is set. A virtual FIQ is pending when `req_vfiq` or `hyp_ctl[4]` is set. A virtual abort is pending only from `hyp_ctl[5]`.
- R3: A virtual source qualifies only when all of the following hold: its class mask bit is clear, its routing bit is set (`hyp_ctl[0]` IRQ, `hyp_ctl[1]` FIQ, `hyp_ctl[2]` abort), `in_hyp` is low and `in_secure` is low.
- R4: A physical IRQ, FIQ or abort qualifies only when `mask_i`, `mask_f` or `mask_a` respectively is clear.
- R5: Reset and send-event requests qualify whatever the masks, routing, mode and security state are.
- R6: `take` and `cause` are registered on the rising clock edge, one cycle after the inputs. A synchronous active-high `rst` clears both. When nothing qualifies, `take` is 0 and `cause` is 0.
- R7: `wake` is high whenever any physical request (IRQ, FIQ, abort, reset, send-event) is pending, whatever the masks say.
- R8: For `wake`, a virtual class counts only when its routing bit is set and the core is neither in hypervisor mode nor in secure state. Mask bits are ignored.
- R9: `status` bit 7 (I), bit 6 (F) and bit 8 (A) each report the virtual pending value when the class is routed and the core is neither in hypervisor mode nor in secure state. Otherwise they report the physical request line. All other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_irq | input | 1 | Physical normal interrupt request |
| req_fiq | input | 1 | Physical fast interrupt request |
| req_abt | input | 1 | Physical asynchronous abort request |
| req_virq | input | 1 | Virtual normal interrupt line |
| req_vfiq | input | 1 | Virtual fast interrupt line |
| req_reset | input | 1 | Reset request |
| req_sev | input | 1 | Send-event request |
| hyp_ctl | input | 6 | [0..2] route IRQ/FIQ/abort, [3..5] inject IRQ/FIQ/abort |
| mask_i | input | 1 | IRQ mask bit |
| mask_f | input | 1 | FIQ mask bit |
| mask_a | input | 1 | Abort mask bit |
| in_hyp | input | 1 | Core is in hypervisor mode |
| in_secure | input | 1 | Core is in secure state |
| take | output | 1 | Registered take strobe |
| cause | output | 3 | Registered winning cause code |
| wake | output | 1 | Wake-from-wait indication |
| status | output | STAT_W | Pending status word |

## Verification
The bench targets adjacent physical/virtual pairs, where a swapped priority would report cause 1 instead of 0, or 3 instead of 2. It also covers a virtual abort injected with no line at all, which a design that looked for a line would never take. It holds hypervisor mode or secure state with injections set; a design that missed that gate would take a virtual cause or raise wake. It checks masked physical requests, which must still raise wake and the status bit while producing no take. Status words are checked with the routing bits both on and off, so a design that used the wrong source or the wrong bit position would show up.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

    localparam int NUM_CAUSE = 8;
    localparam int CAUSE_W   = $clog2(NUM_CAUSE);
    localparam int HCTL_W    = 6;

    // Status-word bit positions, fixed by the status-register layout.
    localparam int ST_BIT_A = 8;
    localparam int ST_BIT_I = 7;
    localparam int ST_BIT_F = 6;

    typedef enum logic [CAUSE_W-1:0] {
        CZ_PIRQ  = 3'd0,
        CZ_VIRQ  = 3'd1,
        CZ_PFIQ  = 3'd2,
        CZ_VFIQ  = 3'd3,
        CZ_PABT  = 3'd4,
        CZ_VABT  = 3'd5,
        CZ_RESET = 3'd6,
        CZ_SEV   = 3'd7
    } cause_e;

    // Hypervisor control word: bit 0 is route_i, bit 5 is inj_a.
    typedef struct packed {
        logic inj_a;
        logic inj_f;
        logic inj_i;
        logic route_a;
        logic route_f;
        logic route_i;
    } hctl_t;

endpackage

// File: rtl/exc_src_qual.sv
module exc_src_qual
    import exc_prio_pkg::*;
(
    input  logic                 req_irq,
    input  logic                 req_fiq,
    input  logic                 req_abt,
    input  logic                 req_virq,
    input  logic                 req_vfiq,
    input  logic                 req_reset,
    input  logic                 req_sev,
    input  hctl_t                ctl,
    input  logic                 mask_i,
    input  logic                 mask_f,
    input  logic                 mask_a,
    input  logic                 in_hyp,
    input  logic                 in_secure,
    output logic [NUM_CAUSE-1:0] qual
);

    logic vpend_i;
    logic vpend_f;
    logic vpend_a;
    logic virt_ok;

    always_comb begin
        vpend_i = req_virq | ctl.inj_i;
        vpend_f = req_vfiq | ctl.inj_f;
        vpend_a = ctl.inj_a;
        virt_ok = ~in_hyp & ~in_secure;

        qual           = '0;
        qual[CZ_PIRQ]  = req_irq & ~mask_i;
        qual[CZ_VIRQ]  = vpend_i & ~mask_i & ctl.route_i & virt_ok;
        qual[CZ_PFIQ]  = req_fiq & ~mask_f;
        qual[CZ_VFIQ]  = vpend_f & ~mask_f & ctl.route_f & virt_ok;
        qual[CZ_PABT]  = req_abt & ~mask_a;
        qual[CZ_VABT]  = vpend_a & ~mask_a & ctl.route_a & virt_ok;
        qual[CZ_RESET] = req_reset;
        qual[CZ_SEV]   = req_sev;
    end

endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign grant[g]  = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) begin
                idx = idx | W'(k);
            end
        end
    end

endmodule

// File: rtl/exc_wake_stat.sv
module exc_wake_stat
    import exc_prio_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic              req_abt,
    input  logic              req_virq,
    input  logic              req_vfiq,
    input  logic              req_reset,
    input  logic              req_sev,
    input  hctl_t             ctl,
    input  logic              in_hyp,
    input  logic              in_secure,
    output logic              wake,
    output logic [STAT_W-1:0] status
);

    logic virt_ok;
    logic vpend_i;
    logic vpend_f;
    logic phys_any;
    logic virt_any;

    always_comb begin
        virt_ok  = ~in_hyp & ~in_secure;
        vpend_i  = req_virq | ctl.inj_i;
        vpend_f  = req_vfiq | ctl.inj_f;
        phys_any = req_irq | req_fiq | req_abt | req_reset | req_sev;
        virt_any = ((vpend_i & ctl.route_i) |
                    (vpend_f & ctl.route_f) |
                    (ctl.inj_a & ctl.route_a)) & virt_ok;
        wake     = phys_any | virt_any;

        status           = '0;
        status[ST_BIT_I] = (virt_ok & ctl.route_i) ? vpend_i   : req_irq;
        status[ST_BIT_F] = (virt_ok & ctl.route_f) ? vpend_f   : req_fiq;
        status[ST_BIT_A] = (virt_ok & ctl.route_a) ? ctl.inj_a : req_abt;
    end

endmodule

// File: rtl/exc_prio_top.sv
module exc_prio_top
    import exc_prio_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_irq,
    input  logic                          req_fiq,
    input  logic                          req_abt,
    input  logic                          req_virq,
    input  logic                          req_vfiq,
    input  logic                          req_reset,
    input  logic                          req_sev,
    input  logic [exc_prio_pkg::HCTL_W-1:0]  hyp_ctl,
    input  logic                          mask_i,
    input  logic                          mask_f,
    input  logic                          mask_a,
    input  logic                          in_hyp,
    input  logic                          in_secure,
    output logic                          take,
    output logic [exc_prio_pkg::CAUSE_W-1:0] cause,
    output logic                          wake,
    output logic [STAT_W-1:0]             status
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TAKE = 1'b1
    } arb_state_e;

    hctl_t                ctl;
    logic [NUM_CAUSE-1:0] qual;
    logic                 any_q;
    logic [CAUSE_W-1:0]   win_idx;
    arb_state_e           state_q;
    arb_state_e           state_d;
    cause_e               cause_q;
    cause_e               cause_d;

    assign ctl = hctl_t'(hyp_ctl);

    exc_src_qual u_qual (
        .req_irq   (req_irq),
        .req_fiq   (req_fiq),
        .req_abt   (req_abt),
        .req_virq  (req_virq),
        .req_vfiq  (req_vfiq),
        .req_reset (req_reset),
        .req_sev   (req_sev),
        .ctl       (ctl),
        .mask_i    (mask_i),
        .mask_f    (mask_f),
        .mask_a    (mask_a),
        .in_hyp    (in_hyp),
        .in_secure (in_secure),
        .qual      (qual)
    );

    exc_prio_enc #(.N(NUM_CAUSE)) u_enc (
        .req (qual),
        .any (any_q),
        .idx (win_idx)
    );

    exc_wake_stat #(.STAT_W(STAT_W)) u_ws (
        .req_irq   (req_irq),
        .req_fiq   (req_fiq),
        .req_abt   (req_abt),
        .req_virq  (req_virq),
        .req_vfiq  (req_vfiq),
        .req_reset (req_reset),
        .req_sev   (req_sev),
        .ctl       (ctl),
        .in_hyp    (in_hyp),
        .in_secure (in_secure),
        .wake      (wake),
        .status    (status)
    );

    // Next-state decision: IDLE/TAKE chosen each cycle from qualification.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = any_q ? ST_TAKE : ST_IDLE;
            ST_TAKE: state_d = any_q ? ST_TAKE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        cause_d = any_q ? cause_e'(win_idx) : CZ_PIRQ;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cause_q <= CZ_PIRQ;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // Outputs.
    always_comb begin
        take  = (state_q == ST_TAKE);
        cause = cause_q;
    end

endmodule

// File: rtl/exc_prio_chk.sv
module exc_prio_chk #(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_irq,
    input logic              req_fiq,
    input logic              req_abt,
    input logic              req_reset,
    input logic              req_sev,
    input logic              mask_i,
    input logic              in_hyp,
    input logic              in_secure,
    input logic              take,
    input logic [2:0]        cause,
    input logic              wake,
    input logic [STAT_W-1:0] status
);

    localparam logic [STAT_W-1:0] STAT_USED = STAT_W'(9'h1C0);

    logic phys_any;
    assign phys_any = req_irq | req_fiq | req_abt | req_reset | req_sev;

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !take |-> cause == 3'd0);

    p_rst_clear_r6: assert property (@(posedge clk)
        rst |=> (!take && cause == 3'd0));

    p_pirq_first_r1: assert property (@(posedge clk) disable iff (rst)
        (req_irq && !mask_i) |=> (take && cause == 3'd0));

    p_pirq_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (take && cause == 3'd0) |-> $past(req_irq && !mask_i));

    p_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        (req_reset || req_sev) |=> take);

    p_virt_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (in_hyp || in_secure) |=>
            !(take && (cause == 3'd1 || cause == 3'd3 || cause == 3'd5)));

    p_wake_phys_r7: assert property (@(posedge clk) disable iff (rst)
        phys_any |-> wake);

    p_wake_virt_r8: assert property (@(posedge clk) disable iff (rst)
        ((in_hyp || in_secure) && !phys_any) |-> !wake);

    p_stat_spare_r9: assert property (@(posedge clk) disable iff (rst)
        (status & ~STAT_USED) == '0);

endmodule

bind exc_prio_top exc_prio_chk #(.STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_irq   (req_irq),
    .req_fiq   (req_fiq),
    .req_abt   (req_abt),
    .req_reset (req_reset),
    .req_sev   (req_sev),
    .mask_i    (mask_i),
    .in_hyp    (in_hyp),
    .in_secure (in_secure),
    .take      (take),
    .cause     (cause),
    .wake      (wake),
    .status    (status)
);

// File: tb/tb_exc_prio_top.sv
module tb_exc_prio_top;

    localparam int STAT_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_irq, req_fiq, req_abt, req_virq, req_vfiq;
    logic              req_reset, req_sev;
    logic [5:0]        hyp_ctl;
    logic              mask_i, mask_f, mask_a, in_hyp, in_secure;
    logic              take;
    logic [2:0]        cause;
    logic              wake;
    logic [STAT_W-1:0] status;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    exc_prio_top #(.STAT_W(STAT_W)) dut (
        .clk(clk), .rst(rst),
        .req_irq(req_irq), .req_fiq(req_fiq), .req_abt(req_abt),
        .req_virq(req_virq), .req_vfiq(req_vfiq),
        .req_reset(req_reset), .req_sev(req_sev),
        .hyp_ctl(hyp_ctl),
        .mask_i(mask_i), .mask_f(mask_f), .mask_a(mask_a),
        .in_hyp(in_hyp), .in_secure(in_secure),
        .take(take), .cause(cause), .wake(wake), .status(status)
    );

    // Expected {take, cause} from the requirements.
    function automatic logic [3:0] exp_pick();
        logic vok, vi, vf, va;
        vok = !in_hyp && !in_secure;
        vi  = req_virq | hyp_ctl[3];
        vf  = req_vfiq | hyp_ctl[4];
        va  = hyp_ctl[5];
        if (req_irq && !mask_i)                     return 4'b1_000;
        if (vi && !mask_i && hyp_ctl[0] && vok)      return 4'b1_001;
        if (req_fiq && !mask_f)                     return 4'b1_010;
        if (vf && !mask_f && hyp_ctl[1] && vok)      return 4'b1_011;
        if (req_abt && !mask_a)                     return 4'b1_100;
        if (va && !mask_a && hyp_ctl[2] && vok)      return 4'b1_101;
        if (req_reset)                              return 4'b1_110;
        if (req_sev)                                return 4'b1_111;
        return 4'b0_000;
    endfunction

    function automatic logic exp_wake();
        logic vok;
        vok = !in_hyp && !in_secure;
        return req_irq | req_fiq | req_abt | req_reset | req_sev |
               (vok & (((req_virq | hyp_ctl[3]) & hyp_ctl[0]) |
                       ((req_vfiq | hyp_ctl[4]) & hyp_ctl[1]) |
                       (hyp_ctl[5] & hyp_ctl[2])));
    endfunction

    function automatic logic [STAT_W-1:0] exp_status();
        logic vok;
        logic [STAT_W-1:0] s;
        vok  = !in_hyp && !in_secure;
        s    = '0;
        s[7] = (vok && hyp_ctl[0]) ? (req_virq | hyp_ctl[3]) : req_irq;
        s[6] = (vok && hyp_ctl[1]) ? (req_vfiq | hyp_ctl[4]) : req_fiq;
        s[8] = (vok && hyp_ctl[2]) ? hyp_ctl[5] : req_abt;
        return s;
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        req_irq = 0; req_fiq = 0; req_abt = 0; req_virq = 0; req_vfiq = 0;
        req_reset = 0; req_sev = 0; hyp_ctl = '0;
        mask_i = 0; mask_f = 0; mask_a = 0; in_hyp = 0; in_secure = 0;
    endtask

    // Called at a falling edge with inputs already set.
    task automatic step(input string t_take, input string t_wake, input string t_stat);
        logic [3:0]        ep;
        logic              ew;
        logic [STAT_W-1:0] es;
        #1;
        ep = exp_pick();
        ew = exp_wake();
        es = exp_status();
        chk(wake === ew, t_wake, "wake", 32'(wake), 32'(ew));
        chk(status === es, t_stat, "status", status, es);
        @(posedge clk);
        @(negedge clk);
        chk(take === ep[3], t_take, "take", 32'(take), 32'(ep[3]));
        chk(cause === ep[2:0], t_take, "cause", 32'(cause), 32'(ep[2:0]));
    endtask

    task automatic final_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        final_report();
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        clear_in();
        req_irq = 1; req_sev = 1;
        rst = 1;
        @(negedge clk); @(negedge clk);
        // R6: reset clears the registered outputs
        chk(take === 1'b0, "R6", "reset take", 32'(take), 0);
        chk(cause === 3'd0, "R6", "reset cause", 32'(cause), 0);
        rst = 0;
        clear_in();

        // R6: nothing pending
        step("R6", "R7", "R9");
        // R5: send-event alone with every mask set
        mask_i = 1; mask_f = 1; mask_a = 1; in_hyp = 1; req_sev = 1;
        step("R5", "R7", "R9");
        // R1: reset outranks send-event
        req_reset = 1;
        step("R1", "R7", "R9");
        clear_in();
        // R2: injected virtual IRQ with no line
        hyp_ctl = 6'b001_001;
        step("R2", "R8", "R9");
        // R3: hypervisor mode blocks it, wake and status follow
        in_hyp = 1;
        step("R3", "R8", "R9");
        in_hyp = 0; in_secure = 1;
        step("R3", "R8", "R9");
        clear_in();
        // R2: virtual abort only from injection
        hyp_ctl = 6'b100_100;
        step("R2", "R8", "R9");
        // R3: masked virtual abort: no take, still wakes
        mask_a = 1;
        step("R3", "R8", "R9");
        clear_in();
        // R4: masked physical IRQ: no take, wake and status bit 7 set
        req_irq = 1; mask_i = 1;
        step("R4", "R7", "R9");
        // R1: physical IRQ beats routed virtual IRQ
        mask_i = 0; req_virq = 1; hyp_ctl = 6'b000_001;
        step("R1", "R8", "R9");
        clear_in();
        // R1: masked physical FIQ lets virtual FIQ win
        req_fiq = 1; mask_f = 1; req_vfiq = 1; hyp_ctl = 6'b000_010;
        req_abt = 1;
        step("R1", "R7", "R9");
        clear_in();
        // R9: virtual IRQ pending but not routed: status I shows the physical line
        req_virq = 1; hyp_ctl = 6'b001_000;
        step("R9", "R8", "R9");
        // R6: mid-run reset with a request present
        req_sev = 1; rst = 1;
        @(posedge clk); @(negedge clk);
        chk(take === 1'b0, "R6", "mid reset take", 32'(take), 0);
        rst = 0;
        clear_in();

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b, c;
            a = $urandom; b = $urandom; c = $urandom;
            req_irq   = a[0] & b[0] & c[0];
            req_fiq   = a[1] & b[1];
            req_abt   = a[2] & b[2];
            req_virq  = a[3] & b[3];
            req_vfiq  = a[4] & b[4];
            req_reset = a[5] & b[5] & c[5];
            req_sev   = a[6] & b[6];
            hyp_ctl   = {c[13:11] & b[13:11], c[10:8] | b[10:8]};
            mask_i    = c[14] & a[14];
            mask_f    = c[15] & a[15];
            mask_a    = c[16] & a[16];
            in_hyp    = c[17] & a[17];
            in_secure = c[18] & a[18];
            step("R1", "R7", "R9");
        end

        final_report();
    end

endmodule